// File: doc/BRIEF.md
# Flash Write Status Word Generator

This block builds the byte that a flash device returns when the host reads it while an embedded program or erase is running. The operating mode comes in as an input: idle, program, erase, reading while an erase is suspended, or programming while an erase is suspended. Alongside it come the data being programmed, the stored contents at the read address, whether that address lies in a sector picked for erase, a pulse-limit flag and a read strobe. From these the block drives a polling bit, two toggle bits, a failure bit, an erase-timer bit and a ready line.

The two toggle bits are flip-flops, and each has its own qualifier. The main toggle advances on every read made while the device is busy. The alternate toggle advances only on reads that hit an erase-selected sector, and only in erase or suspended-read mode. A failure latch records a pulse-count overrun, or an attempt to program a 1 over a stored 0. It stays set until a reset command arrives. The timing of the embedded algorithms and the array contents are not part of the block: they arrive on its inputs.

Top module: `fsw_top`

## Requirements
- R1: After `rst`, both toggle flops and the failure latch are 0. In idle mode (`mode`=0, and the unused codes 5 to 7) `status` equals `array_data` and `ready` is 1.
- R2: In program mode (`mode`=1), bit 7 is the inverse of `prog_data[7]`, bit 6 is the main toggle, bit 5 is the failure latch, bit 3 is 0, bit 2 is the held alternate toggle, and `ready` is 0.
- R3: In erase mode (`mode`=2), bit 7 is 0, bit 6 is the main toggle, bit 5 is the failure latch, bit 3 is 1, bit 2 is the alternate toggle, and `ready` is 0.
- R4: The main toggle inverts on each clock edge that sees `rd_stb` in modes 1, 2 or 4, and holds at all other times. So a read in mode 3 leaves it unchanged.
- R5: The alternate toggle inverts on each clock edge that sees `rd_stb` with `in_erase_sector`=1 in mode 2 or 3, and holds at all other times. This includes program mode and reads outside the selected sectors.
- R6: In suspended-read mode (`mode`=3) with `in_erase_sector`=1, bit 7 is 1, bit 6 is the held main toggle, bit 5 is 0, bit 3 is 0, bit 2 is the alternate toggle, and `ready` is 1.
- R7: In suspended-read mode with `in_erase_sector`=0, `status` equals `array_data` and `ready` is 1.
- R8: In suspend-program mode (`mode`=4), bit 7 is the inverse of `prog_data[7]`, bit 6 is the main toggle, bit 5 is the failure latch, bits 3 and 2 are 0, and `ready` is 0.
- R9: The failure latch sets on an edge that sees `limit_hit` in mode 1, 2 or 4. It also sets on an edge in mode 1 or 4 when any bit is 1 in `prog_data` and 0 in `array_data`. Once set it holds until an edge that sees `reset_cmd`, and `reset_cmd` takes priority over a set in the same cycle.
- R10: In modes 1 to 3 (mode 3 with `in_erase_sector`=1) and in mode 4, bits 4, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode: 0 idle, 1 program, 2 erase, 3 suspended read, 4 suspend-program |
| rd_stb | input | 1 | Host read strobe, one per read |
| in_erase_sector | input | 1 | Read address lies in an erase-selected sector |
| prog_data | input | 8 | Data being programmed at the read address |
| array_data | input | 8 | Stored contents at the read address |
| limit_hit | input | 1 | Internal pulse-count limit exceeded |
| reset_cmd | input | 1 | Reset command; clears the failure latch |
| status | output | 8 | Status byte, or array data in read modes |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
The assertions take for granted that `mode` stays within the five defined codes while the device is busy. They also assume that `prog_data` is stable for the whole length of an operation, because the polling bit is checked against it on every cycle. The stimulus changes mode, data and address only on falling clock edges, and it keeps `array_data` all ones during program reads unless a test means to trigger the program-over-zero failure. This keeps the latch from being set by accident.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [2:0] {
        MD_IDLE      = 3'd0,
        MD_PROG      = 3'd1,
        MD_ERASE     = 3'd2,
        MD_SUSP_RD   = 3'd3,
        MD_SUSP_PROG = 3'd4
    } op_mode_e;

    localparam int WORD_W   = 8;
    localparam int POLL_POS = 7;
    localparam int TOG_POS  = 6;
    localparam int FAIL_POS = 5;
    localparam int TMR_POS  = 3;
    localparam int ALT_POS  = 2;

    typedef struct packed {
        logic poll;
        logic tog;
        logic fail;
        logic tmr;
        logic alt;
    } stat_bits_s;

    function automatic op_mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'd1:    return MD_PROG;
            3'd2:    return MD_ERASE;
            3'd3:    return MD_SUSP_RD;
            3'd4:    return MD_SUSP_PROG;
            default: return MD_IDLE;
        endcase
    endfunction

    function automatic logic mode_busy(input op_mode_e m);
        return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SUSP_PROG);
    endfunction

    function automatic logic mode_writes(input op_mode_e m);
        return (m == MD_PROG) || (m == MD_SUSP_PROG);
    endfunction

endpackage

// File: rtl/fsw_toggle_cell.sv
module fsw_toggle_cell (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (adv)
            q <= ~q;
    end
endmodule

// File: rtl/fsw_fail_latch.sv
module fsw_fail_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end
endmodule

// File: rtl/fsw_word_mux.sv
module fsw_word_mux
    import fsw_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  op_mode_e        md,
    input  logic            prog_msb,
    input  logic            in_sector,
    input  logic [DW-1:0]   arr,
    input  logic            tog_q,
    input  logic            alt_q,
    input  logic            fail_q,
    output logic [DW-1:0]   word,
    output logic            rdy
);
    stat_bits_s sb;
    logic       pass_array;

    always_comb begin
        sb         = '0;
        pass_array = 1'b0;
        rdy        = 1'b1;
        case (md)
            MD_PROG: begin
                sb.poll = ~prog_msb;
                sb.tog  = tog_q;
                sb.fail = fail_q;
                sb.alt  = alt_q;
                rdy     = 1'b0;
            end
            MD_ERASE: begin
                sb.tog  = tog_q;
                sb.fail = fail_q;
                sb.tmr  = 1'b1;
                sb.alt  = alt_q;
                rdy     = 1'b0;
            end
            MD_SUSP_RD: begin
                if (in_sector) begin
                    sb.poll = 1'b1;
                    sb.tog  = tog_q;
                    sb.alt  = alt_q;
                end else begin
                    pass_array = 1'b1;
                end
            end
            MD_SUSP_PROG: begin
                sb.poll = ~prog_msb;
                sb.tog  = tog_q;
                sb.fail = fail_q;
                rdy     = 1'b0;
            end
            default: pass_array = 1'b1;
        endcase
    end

    always_comb begin
        word = '0;
        if (pass_array) begin
            word = arr;
        end else begin
            word[POLL_POS] = sb.poll;
            word[TOG_POS]  = sb.tog;
            word[FAIL_POS] = sb.fail;
            word[TMR_POS]  = sb.tmr;
            word[ALT_POS]  = sb.alt;
        end
    end
endmodule

// File: rtl/fsw_top.sv
module fsw_top
    import fsw_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    mode,
    input  logic          rd_stb,
    input  logic          in_erase_sector,
    input  logic [DW-1:0] prog_data,
    input  logic [DW-1:0] array_data,
    input  logic          limit_hit,
    input  logic          reset_cmd,
    output logic [DW-1:0] status,
    output logic          ready
);
    op_mode_e md;
    logic     adv_tog, adv_alt, fail_set;
    logic     tog_q, alt_q, fail_q;
    logic     zero_to_one;

    assign md          = decode_mode(mode);
    assign adv_tog     = rd_stb && mode_busy(md);
    assign adv_alt     = rd_stb && in_erase_sector &&
                         ((md == MD_ERASE) || (md == MD_SUSP_RD));
    assign zero_to_one = |(prog_data & ~array_data);
    assign fail_set    = (limit_hit && mode_busy(md)) ||
                         (zero_to_one && mode_writes(md));

    fsw_toggle_cell u_tog (.clk(clk), .rst(rst), .adv(adv_tog), .q(tog_q));
    fsw_toggle_cell u_alt (.clk(clk), .rst(rst), .adv(adv_alt), .q(alt_q));

    fsw_fail_latch u_fail (
        .clk(clk), .rst(rst), .set(fail_set), .clr(reset_cmd), .q(fail_q)
    );

    fsw_word_mux #(.DW(DW)) u_mux (
        .md(md), .prog_msb(prog_data[DW-1]), .in_sector(in_erase_sector),
        .arr(array_data), .tog_q(tog_q), .alt_q(alt_q), .fail_q(fail_q),
        .word(status), .rdy(ready)
    );
endmodule

// File: rtl/fsw_chk.sv
module fsw_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    mode,
    input logic          rd_stb,
    input logic          in_erase_sector,
    input logic [DW-1:0] prog_data,
    input logic          reset_cmd,
    input logic [DW-1:0] status,
    input logic          ready,
    input logic          tog_q,
    input logic          alt_q,
    input logic          fail_q
);
    logic busy_m;
    logic alt_m;
    assign busy_m = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd4);
    assign alt_m  = rd_stb && in_erase_sector && ((mode == 3'd2) || (mode == 3'd3));

    // R2
    prog_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1) |-> (status[DW-1] == ~prog_data[DW-1]) && !ready);

    // R3
    erase_row_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2) |-> !status[7] && status[3] && !ready);

    // R4
    tog_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && busy_m) |=> (tog_q != $past(tog_q)));

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && busy_m) |=> $stable(tog_q));

    // R5
    alt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !alt_m |=> $stable(alt_q));

    // R6
    susp_sector_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && in_erase_sector) |-> status[7] && !status[5] && ready);

    // R9
    fail_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !reset_cmd) |=> fail_q);

    // R9
    fail_clr_chk: assert property (@(posedge clk) disable iff (rst)
        reset_cmd |=> !fail_q);

    // R10
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_m || (mode == 3'd3 && in_erase_sector)) |->
            (status[4] == 1'b0) && (status[1:0] == 2'b00));
endmodule

bind fsw_top fsw_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .rd_stb(rd_stb),
    .in_erase_sector(in_erase_sector), .prog_data(prog_data),
    .reset_cmd(reset_cmd), .status(status), .ready(ready),
    .tog_q(tog_q), .alt_q(alt_q), .fail_q(fail_q)
);

// File: tb/sim_fsw_top.sv
module sim_fsw_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode;
    logic       rd_stb, in_erase_sector, limit_hit, reset_cmd;
    logic [7:0] prog_data, array_data, status;
    logic       ready;

    int n_chk = 0;
    int n_fail = 0;
    bit e_tog, e_alt, e_fail;

    always #5 clk = ~clk;

    fsw_top u0 (
        .clk(clk), .rst(rst), .mode(mode), .rd_stb(rd_stb),
        .in_erase_sector(in_erase_sector), .prog_data(prog_data),
        .array_data(array_data), .limit_hit(limit_hit), .reset_cmd(reset_cmd),
        .status(status), .ready(ready)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_word();
        logic [7:0] w;
        logic       r;
        w = 8'h00;
        r = 1'b1;
        case (mode)
            3'd1: begin w = {~prog_data[7], e_tog, e_fail, 1'b0, 1'b0, e_alt, 2'b00}; r = 1'b0; end
            3'd2: begin w = {1'b0, e_tog, e_fail, 1'b0, 1'b1, e_alt, 2'b00}; r = 1'b0; end
            3'd3: w = in_erase_sector ? {1'b1, e_tog, 1'b0, 1'b0, 1'b0, e_alt, 2'b00} : array_data;
            3'd4: begin w = {~prog_data[7], e_tog, e_fail, 5'b00000}; r = 1'b0; end
            default: w = array_data;
        endcase
        return {r, w};
    endfunction

    // one host read: check word and ready, then advance the bench's toggle model
    task automatic read_chk(string req);
        logic [8:0] e;
        @(negedge clk);
        rd_stb = 1'b1;
        #1;
        e = expect_word();
        check(req, status, e[7:0]);
        check({req, " ready"}, {7'd0, ready}, {7'd0, e[8]});
        if (mode == 3'd1 || mode == 3'd2 || mode == 3'd4) e_tog = ~e_tog;
        if (in_erase_sector && (mode == 3'd2 || mode == 3'd3)) e_alt = ~e_alt;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_fail_in(logic lim, logic rcmd);
        @(negedge clk);
        limit_hit = lim;
        reset_cmd = rcmd;
        @(negedge clk);
        limit_hit = 1'b0;
        reset_cmd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        mode = 3'd0; array_data = 8'hA5;
        #1;
        check("R1 idle word", status, 8'hA5);
        check("R1 idle ready", {7'd0, ready}, 8'h01);
        mode = 3'd6;
        #1;
        check("R1 unused code", status, 8'hA5);
    endtask

    task automatic t_program();
        @(negedge clk);
        mode = 3'd1; array_data = 8'hFF; prog_data = 8'h80; in_erase_sector = 1'b1;
        read_chk("R2 R4 R5 R10 prog read 1");
        read_chk("R2 R4 R5 prog read 2");
        prog_data = 8'h12;
        read_chk("R2 R4 prog read 3");
    endtask

    task automatic t_erase();
        @(negedge clk);
        mode = 3'd2; in_erase_sector = 1'b1;
        read_chk("R3 R4 R5 erase in sector 1");
        read_chk("R3 R5 erase in sector 2");
        read_chk("R3 R5 erase in sector 3");
        in_erase_sector = 1'b0;
        read_chk("R3 R5 erase outside sector 1");
        read_chk("R3 R5 erase outside sector 2");
    endtask

    task automatic t_susp_read();
        @(negedge clk);
        mode = 3'd3; in_erase_sector = 1'b1;
        read_chk("R6 R4 R5 susp in sector 1");
        read_chk("R6 R4 R5 susp in sector 2");
        in_erase_sector = 1'b0; array_data = 8'h3C;
        read_chk("R7 susp outside 1");
        array_data = 8'hC3;
        read_chk("R7 susp outside 2");
        in_erase_sector = 1'b1;
        read_chk("R5 R6 alt held after outside reads");
    endtask

    task automatic t_susp_prog();
        @(negedge clk);
        mode = 3'd4; array_data = 8'hFF; prog_data = 8'h00;
        read_chk("R8 R4 susp prog 1");
        prog_data = 8'h80;
        read_chk("R8 R4 susp prog 2");
    endtask

    task automatic t_fail();
        @(negedge clk);
        mode = 3'd0;
        pulse_fail_in(1'b1, 1'b0);
        mode = 3'd1; array_data = 8'hFF; prog_data = 8'h40;
        read_chk("R9 idle limit ignored");
        pulse_fail_in(1'b1, 1'b0);
        e_fail = 1'b1;
        read_chk("R9 limit sets DQ5");
        mode = 3'd0;
        pulse_fail_in(1'b0, 1'b0);
        mode = 3'd2; in_erase_sector = 1'b1;
        read_chk("R9 latch holds");
        pulse_fail_in(1'b0, 1'b1);
        e_fail = 1'b0;
        read_chk("R9 reset command clears");
    endtask

    task automatic t_conflict();
        @(negedge clk);
        mode = 3'd1; array_data = 8'h0F; prog_data = 8'h30;
        @(negedge clk);
        array_data = 8'hFF;
        e_fail = 1'b1;
        read_chk("R9 program one over zero");
        pulse_fail_in(1'b1, 1'b1);
        e_fail = 1'b0;
        read_chk("R9 reset priority over set");
    endtask

    initial begin
        rst = 1'b1; mode = 3'd0; rd_stb = 1'b0; in_erase_sector = 1'b0;
        limit_hit = 1'b0; reset_cmd = 1'b0; prog_data = 8'h00; array_data = 8'h00;
        e_tog = 1'b0; e_alt = 1'b0; e_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_erase();
        t_susp_read();
        t_susp_prog();
        t_fail();
        t_conflict();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule